// File: doc/BRIEF.md
# Reload Timer with Triggered Start

An 8-bit down counter that divides a count-source tick stream by a programmable value. A reload register holds the division constant. Each time the counter is at zero and another enabled tick arrives, the counter underflows. On underflow it takes the reload value again, raises an interrupt request flag and keeps counting. Software can load the counter and the reload register together while the timer is stopped. It can also rewrite the reload register alone at any time, and that new value takes effect at the next underflow.

An optional start circuit gates the tick stream. With trigger-select on, ticks reach the counter only after a chosen edge has been seen on an external pin. The circuit can watch for falling edges only, rising edges only, or both. Once it has seen the edge it stays open until the pin-enable bit is cleared. With auto-stop also on, the first underflow closes the gate again, which gives a one-shot timer that is re-armed by the next pin edge. The pin is synchronised to the system clock inside the block.

Top module: `reload_trig_timer`

## Requirements
- R1: After reset the counter reads 0, the reload register holds 0, the interrupt flag is 0 and the start gate is closed.
- R2: A combined write (`wr_both`) while `run_en` is 0 loads `wr_data` into both the counter and the reload register, visible on `count_q` one clock later. A combined write while `run_en` is 1 is ignored and changes neither register.
- R3: A reload-only write (`wr_reload`) changes only the reload register, whatever `run_en` is. The counter reaches that value at its next underflow, and the write does not disturb the count in progress.
- R4: While `run_en` is 1 and the tick is enabled, each `tick` pulse lowers a nonzero count by one. With `run_en` at 0, or with no tick, the count holds.
- R5: An enabled tick while the count is 0 is an underflow. It reloads the counter from the reload register and sets `irq_flag`, so a reload value n gives one underflow every n+1 enabled ticks (n = 0 to 255).
- R6: With `trig_sel` at 1, ticks are enabled only while the start gate is open. With `trig_sel` at 0, the gate has no effect and every tick is enabled.
- R7: While `pin_en` is 0 the pin is ignored and the start gate is held closed. Once opened, the gate stays open until `pin_en` returns to 0 or reset occurs.
- R8: With `edge_both` at 1, either pin edge opens the gate. With `edge_both` at 0, `edge_rise` selects the edge: 1 means rising and 0 means falling.
- R9: With `auto_stop` and `trig_sel` both 1, an underflow closes the start gate, and later ticks are ignored until a new pin edge. With `trig_sel` at 0, `auto_stop` has no effect.
- R10: `irq_flag` stays set until `irq_take` or `skip_take` is 1 at a clock edge. If an underflow happens in the same cycle as a clear, the flag stays set.
- R11: A pin change applied just before clock edge k opens the gate at edge k+2 (two synchroniser flops and one edge-detect flop). A tick first counts at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_both | input | 1 | Load counter and reload register from `wr_data` (only while stopped) |
| wr_reload | input | 1 | Load the reload register alone from `wr_data` |
| wr_data | input | CNT_W | Write data |
| run_en | input | 1 | Counting allowed |
| trig_sel | input | 1 | Gate the ticks with the start circuit |
| pin_en | input | 1 | Let the pin drive the start circuit; 0 clears the gate |
| edge_both | input | 1 | 1: both edges open the gate |
| edge_rise | input | 1 | With `edge_both` = 0: 1 rising, 0 falling |
| auto_stop | input | 1 | Close the gate at underflow (with `trig_sel`) |
| tick | input | 1 | Single-cycle count-source pulse |
| pin_in | input | 1 | Asynchronous external pin |
| irq_take | input | 1 | Interrupt acceptance; clears the flag |
| skip_take | input | 1 | Skip-test acknowledge; clears the flag |
| count_q | output | CNT_W | Live counter value |
| irq_flag | output | 1 | Underflow interrupt request flag |

## Verification
Writes, ticks and flag clears act at the clock edge that samples them, so `count_q` and `irq_flag` are due one cycle after the stimulus. A pin edge needs three edges to open the gate, and the first tick it allows counts at the fourth. The bench drives every input on the falling clock edge and steps a cycle model of the requirements at the same moment. It compares both outputs on the next falling edge, after exactly one rising edge, so each result is read in the cycle it is due. Directed checks at R11 place ticks on the third and fourth edge after a pin change to test the gate latency exactly.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } rtt_edges_t;

   // Picks the qualifying edge for the chosen sensitivity.
   function automatic logic rtt_edge_match(rtt_edges_t e, logic both, logic rise_sel);
      if (both) return e.rise | e.fall;
      return rise_sel ? e.rise : e.fall;
   endfunction
endpackage

// File: rtl/rtt_pin_sync.sv
module rtt_pin_sync
   import rtt_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_in,
   output rtt_edges_t edges
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtt_pin_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1:0] are the synchroniser flops, chain[STAGES] the previous sample.
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_in};
   end

   assign edges.rise =  chain[STAGES-1] & ~chain[STAGES];
   assign edges.fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/rtt_start_latch.sv
module rtt_start_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_en,
   input  logic hit,
   input  logic stop,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed <= 1'b0;
      else if (!pin_en) armed <= 1'b0;
      else if (stop)    armed <= 1'b0;
      else if (hit)     armed <= 1'b1;
   end
endmodule

// File: rtl/rtt_down_counter.sv
module rtt_down_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             cnt_en,
   input  logic             wr_both,
   input  logic             wr_reload,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_q,
   output logic             underflow
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] reload_q;
   logic             load_ok;

   assign load_ok   = wr_both & ~run_en;
   assign underflow = cnt_en & (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     reload_q <= '0;
      else if (load_ok || wr_reload)  reload_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count_q <= '0;
      else if (load_ok)   count_q <= wr_data;
      else if (underflow) count_q <= reload_q;
      else if (cnt_en)    count_q <= count_q - ONE;
   end
endmodule

// File: rtl/rtt_irq_flag.sv
module rtt_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/reload_trig_timer.sv
module reload_trig_timer
   import rtt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_both,
   input  logic             wr_reload,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             run_en,
   input  logic             trig_sel,
   input  logic             pin_en,
   input  logic             edge_both,
   input  logic             edge_rise,
   input  logic             auto_stop,
   input  logic             tick,
   input  logic             pin_in,
   input  logic             irq_take,
   input  logic             skip_take,
   output logic [CNT_W-1:0] count_q,
   output logic             irq_flag
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("reload_trig_timer: CNT_W must lie in 2..32");
   end

   rtt_edges_t edges;
   logic       hit, armed, gate_open, cnt_en, underflow, stop;

   rtt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edges(edges)
   );

   assign hit       = pin_en & rtt_edge_match(edges, edge_both, edge_rise);
   assign gate_open = ~trig_sel | armed;
   assign cnt_en    = run_en & tick & gate_open;
   assign stop      = underflow & auto_stop & trig_sel;

   rtt_start_latch u_latch (
      .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .hit(hit), .stop(stop), .armed(armed)
   );

   rtt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_en(cnt_en),
      .wr_both(wr_both), .wr_reload(wr_reload), .wr_data(wr_data),
      .count_q(count_q), .underflow(underflow)
   );

   rtt_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(underflow), .clr(irq_take | skip_take), .flag(irq_flag)
   );
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             tick,
   input logic             trig_sel,
   input logic             auto_stop,
   input logic             wr_both,
   input logic [CNT_W-1:0] wr_data,
   input logic             pin_en,
   input logic             irq_take,
   input logic             skip_take,
   input logic [CNT_W-1:0] count_q,
   input logic             irq_flag,
   input logic             armed
);
   logic en_tick;
   assign en_tick = run_en & tick & (~trig_sel | armed);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_both && !run_en) |=> count_q == $past(wr_data));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_both) |=> $stable(count_q));

   p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_tick && count_q != '0) |=> count_q == $past(count_q) - {{(CNT_W-1){1'b0}}, 1'b1});

   p_uf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_tick && count_q == '0) |=> irq_flag);

   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && trig_sel && !armed) |=> $stable(count_q));

   p_pin_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en |=> !armed);

   p_autostop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_tick && trig_sel && auto_stop && count_q == '0) |=> !armed);

   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_take && !skip_take) |=> irq_flag);

   p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_take || skip_take) && !(en_tick && count_q == '0)) |=> !irq_flag);
endmodule

bind reload_trig_timer rtt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .trig_sel(trig_sel),
   .auto_stop(auto_stop), .wr_both(wr_both), .wr_data(wr_data), .pin_en(pin_en),
   .irq_take(irq_take), .skip_take(skip_take), .count_q(count_q),
   .irq_flag(irq_flag), .armed(armed)
);

// File: tb/reload_trig_timer_test.sv
`timescale 1ns/100ps
module reload_trig_timer_test;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         wr_both = 0, wr_reload = 0;
   logic [W-1:0] wr_data = '0;
   logic run_en = 0, trig_sel = 0, pin_en = 0, edge_both = 0, edge_rise = 0;
   logic auto_stop = 0, tick = 0, pin_in = 0, irq_take = 0, skip_take = 0;
   logic [W-1:0] count_q;
   logic         irq_flag;

   reload_trig_timer #(.CNT_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .wr_both(wr_both), .wr_reload(wr_reload), .wr_data(wr_data),
      .run_en(run_en), .trig_sel(trig_sel), .pin_en(pin_en), .edge_both(edge_both),
      .edge_rise(edge_rise), .auto_stop(auto_stop), .tick(tick), .pin_in(pin_in),
      .irq_take(irq_take), .skip_take(skip_take), .count_q(count_q), .irq_flag(irq_flag)
   );

   int    checks = 0, errors = 0;
   bit    done = 0;
   string tag = "R1";

   // Expected-state model built from the requirements.
   logic [W-1:0] m_cnt = '0, m_rld = '0;
   logic         m_flag = 0, m_gate = 0;
   logic [2:0]   m_pin = '0;  // [0] first sync flop, [1] second, [2] previous sample

   function automatic logic exp_edge(logic now, logic prev, logic both, logic rise);
      if (both) return now != prev;
      if (rise) return now && !prev;
      return !now && prev;
   endfunction

   task automatic chk(string t, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic model_step();
      logic en, uf, hit, n_gate, n_flag;
      logic [W-1:0] n_cnt, n_rld;
      en  = run_en && tick && (!trig_sel || m_gate);
      uf  = en && (m_cnt == '0);
      hit = pin_en && exp_edge(m_pin[1], m_pin[2], edge_both, edge_rise);
      n_gate = !pin_en ? 1'b0 : (uf && auto_stop && trig_sel) ? 1'b0 : hit ? 1'b1 : m_gate;
      n_cnt = (wr_both && !run_en) ? wr_data : uf ? m_rld : en ? m_cnt - 8'd1 : m_cnt;
      n_rld = ((wr_both && !run_en) || wr_reload) ? wr_data : m_rld;
      n_flag = uf ? 1'b1 : (irq_take || skip_take) ? 1'b0 : m_flag;
      m_cnt = n_cnt; m_rld = n_rld; m_gate = n_gate; m_flag = n_flag;
      m_pin = {m_pin[1], m_pin[0], pin_in};
   endtask

   // One clock: model steps on the held inputs, outputs compared on the next falling edge.
   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk({tag, " count"}, int'(count_q), int'(m_cnt));
      chk({tag, " flag"}, int'(irq_flag), int'(m_flag));
      wr_both = 0; wr_reload = 0; irq_take = 0; skip_take = 0; tick = 0;
   endtask

   task automatic cycles(int n, logic tk);
      for (int i = 0; i < n; i++) begin tick = tk; cyc(); end
   endtask

   task automatic load(logic [W-1:0] v);
      wr_both = 1; wr_data = v; cyc();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1";
      chk("R1 reset count", int'(count_q), 0);
      chk("R1 reset flag", int'(irq_flag), 0);

      // R2: load while stopped, ignored while running
      tag = "R2"; load(8'd5);
      chk("R2 load", int'(count_q), 5);
      run_en = 1; load(8'd9);
      chk("R2 load ignored while running", int'(count_q), 5);

      // R4/R5: count down to zero then underflow
      tag = "R4 R5"; cycles(5, 1);
      chk("R4 reached zero", int'(count_q), 0);
      cycles(3, 0);
      chk("R4 no tick holds", int'(count_q), 0);
      cycles(1, 1);
      chk("R5 reload", int'(count_q), 5);
      chk("R5 flag set", int'(irq_flag), 1);

      // R10: hold, clear, set-wins
      tag = "R10"; cycles(4, 0);
      chk("R10 flag held", int'(irq_flag), 1);
      skip_take = 1; cyc();
      chk("R10 skip clears", int'(irq_flag), 0);
      cycles(5, 1);
      tick = 1; irq_take = 1; cyc();
      chk("R10 set wins over clear", int'(irq_flag), 1);
      irq_take = 1; cyc();

      // R3: reload-only write while running
      tag = "R3"; wr_reload = 1; wr_data = 8'd2; tick = 1; cyc();
      chk("R3 count undisturbed", int'(count_q), 4);
      cycles(5, 1);
      chk("R3 new reload used", int'(count_q), 2);

      // R5: n = 0 underflows on every tick
      tag = "R5 n0"; run_en = 0; load(8'd0); run_en = 1;
      irq_take = 1; cyc();
      cycles(4, 1);
      chk("R5 n=0 stays 0", int'(count_q), 0);

      // R6/R8/R11: rising-edge trigger with exact latency
      tag = "R6 R8 R11"; run_en = 0; load(8'd200); run_en = 1;
      trig_sel = 1; pin_en = 1; edge_both = 0; edge_rise = 1;
      cycles(4, 1);
      chk("R6 gate closed holds", int'(count_q), 200);
      pin_in = 1; cycles(3, 1);
      chk("R11 no count before 4th edge", int'(count_q), 200);
      cycles(1, 1);
      chk("R11 counts at 4th edge", int'(count_q), 199);

      // R7: pin_en low closes gate and ignores pin
      tag = "R7"; pin_en = 0; cyc();
      pin_in = 0; cycles(6, 1);
      chk("R7 gate closed by pin_en", int'(count_q), 199);

      // R8: falling edge selects
      tag = "R8 fall"; pin_en = 1; edge_rise = 0; cycles(3, 0);
      pin_in = 1; cycles(5, 1);
      chk("R8 rising ignored in falling mode", int'(count_q), 199);
      pin_in = 0; cycles(6, 1);
      chk("R8 falling opens", int'(count_q), 196);
      pin_en = 0; cyc(); pin_en = 1; edge_both = 1;
      pin_in = 1; cycles(6, 1);
      chk("R8 both-edge mode", int'(count_q), 193);

      // R9: one-shot with auto-stop
      tag = "R9"; pin_en = 0; run_en = 0; cyc(); load(8'd2); run_en = 1;
      pin_en = 1; auto_stop = 1; pin_in = 0; cycles(3, 0);
      cycles(3, 1);
      chk("R9 underflow reached", int'(count_q), 2);
      cycles(4, 1);
      chk("R9 stopped after underflow", int'(count_q), 2);
      trig_sel = 0; cycles(4, 1);
      chk("R9 no effect without trigger", int'(count_q), 1);

      // Random phase, every cycle compared with the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
      tag = "random R4 R5 R9 R10";
      for (int i = 0; i < 4000; i++) begin
         tick      = ($urandom % 3) == 0;
         wr_both   = ($urandom % 40) == 0;
         wr_reload = ($urandom % 40) == 0;
         wr_data   = W'($urandom % 12);
         irq_take  = ($urandom % 15) == 0;
         skip_take = ($urandom % 15) == 0;
         if ($urandom % 50 == 0) run_en = ~run_en;
         if ($urandom % 100 == 0) trig_sel = ~trig_sel;
         if ($urandom % 6 == 0) pin_in = ~pin_in;
         if ($urandom % 60 == 0) pin_en = ~pin_en;
         if ($urandom % 80 == 0) edge_both = ~edge_both;
         if ($urandom % 80 == 0) edge_rise = ~edge_rise;
         if ($urandom % 80 == 0) auto_stop = ~auto_stop;
         model_step();
         @(posedge clk);
         @(negedge clk);
         chk({tag, " count"}, int'(count_q), int'(m_cnt));
         chk({tag, " flag"}, int'(irq_flag), int'(m_flag));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL R4 watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule